// File: doc/BRIEF.md
# Dual-Bank Filter Coefficient Store

This block holds the programmable state of a nine-tap filter: a small configuration word and two complete banks of nine 8-bit coefficients. A host writes it through a narrow port made of an 8-bit data bus, a 3-bit address and a load strobe. The strobe may come from outside the clock domain. It passes through a synchronizer, and each rising edge of the strobe performs exactly one register write.

Each address code either fills a bank, loads the configuration word or switches which bank is active. Only the active bank drives the coefficient vector toward the filter datapath. A host can therefore rewrite the idle bank while processing runs on the other. It then makes the new kernel live with a single select write, and no datapath cycles are lost.

A bank is filled one coefficient per strobe, in order from tap A to tap I, under an internal write pointer. A frame-clear input restarts per-frame processing elsewhere and must leave all stored state alone.

Top module: `kernel_coef_store`

## Requirements
- R1: The address codes decode as follows: 3'b010 writes bank 0, 3'b011 writes bank 1, 3'b100 loads the configuration word, 3'b101 makes bank 0 active and 3'b110 makes bank 1 active. Codes 3'b000, 3'b001 and 3'b111 store nothing.
- R2: Each rising edge of `ldStb` causes exactly one write, using the `addr` and `dataIn` values held during the strobe. The outputs show the write after the third rising `clk` edge that samples `ldStb` high, and not after the second.
- R3: Successive writes to one bank fill taps A through I in order. Tap A occupies `coefOut[7:0]` and tap I occupies `coefOut[71:64]`.
- R4: After tap I of a bank is written, the next write to that bank lands on tap A again.
- R5: Any write to an address other than a bank's own load code returns that bank's write pointer to tap A.
- R6: A select write switches `coefOut` to the chosen bank with the same latency as any other write. Writes to the idle bank never change `coefOut`.
- R7: After `rst_n` is released, both banks and the configuration word are zero, bank 0 is active and both pointers are at tap A.
- R8: A configuration write stores `dataIn[3:0]`, which appears on `cfgWord`.
- R9: Writes to the reserved or no-operation codes leave `coefOut` and `cfgWord` unchanged.
- R10: Asserting `frameClr` leaves the coefficients, the configuration word, the bank selection and both pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, synchronous |
| frameClr | input | 1 | Per-frame clear; stored state is untouched |
| ldStb | input | 1 | Load strobe; a rising edge requests one write |
| addr | input | 3 | Register or command code |
| dataIn | input | 8 | Write data |
| coefOut | output | 72 | Active bank's nine coefficients, tap A in the low byte |
| cfgWord | output | 4 | Configuration word |

## Verification
The assertions assume that `addr` and `dataIn` stay stable from the rising edge of `ldStb` until the synchronized write has taken place. They also assume that `ldStb` stays high and then low for longer than the synchronizer depth, and that no strobe edge arrives while `frameClr` is high. The bench drives every write as a four-cycle high pulse followed by a four-cycle low gap. It holds the address and data for the whole pulse, and it pulses `frameClr` only while the strobe is idle. Under these conditions each strobe maps to exactly one decoded command, and the pointer and bank checks follow from it.

// File: rtl/kcs_pkg.sv
package kcs_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_LOAD_B0 = 3'b010;
  localparam logic [ADDR_W-1:0] ADR_LOAD_B1 = 3'b011;
  localparam logic [ADDR_W-1:0] ADR_CFG     = 3'b100;
  localparam logic [ADDR_W-1:0] ADR_SEL_B0  = 3'b101;
  localparam logic [ADDR_W-1:0] ADR_SEL_B1  = 3'b110;

  // strobes from the control side to the register datapath
  typedef struct packed {
    logic anyWr;
    logic wrB0;
    logic wrB1;
    logic wrCfg;
    logic selB0;
    logic selB1;
  } kcs_ctl_t;
endpackage

// File: rtl/kcs_ctrl.sv
module kcs_ctrl
  import kcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameClr,
  input  logic              ldStb,
  input  logic [ADDR_W-1:0] addr,
  output kcs_ctl_t          ctl
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   wrPulse;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= ldStb;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= {syncQ[MSB-1:0], ldStb};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prevQ <= 1'b0;
    else        prevQ <= syncQ[MSB];
  end

  assign wrPulse = syncQ[MSB] & ~prevQ & ~frameClr;

  always_comb begin
    ctl       = '0;
    ctl.anyWr = wrPulse;
    if (wrPulse) begin
      unique case (addr)
        ADR_LOAD_B0: ctl.wrB0  = 1'b1;
        ADR_LOAD_B1: ctl.wrB1  = 1'b1;
        ADR_CFG:     ctl.wrCfg = 1'b1;
        ADR_SEL_B0:  ctl.selB0 = 1'b1;
        ADR_SEL_B1:  ctl.selB1 = 1'b1;
        default:     ;
      endcase
    end
  end

  // R2: one write per strobe edge
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.anyWr |=> !ctl.anyWr);
  // R1: at most one command decoded per write
  p_dec_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.wrB0, ctl.wrB1, ctl.wrCfg, ctl.selB0, ctl.selB1}));
  // R1: decoded command only with a write pulse
  p_dec_needs_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.wrB0 | ctl.wrB1 | ctl.wrCfg | ctl.selB0 | ctl.selB1) |-> ctl.anyWr);
  // R10: no write while frame clear is high
  p_frame_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frameClr |-> !ctl.anyWr);
endmodule

// File: rtl/kcs_bank.sv
module kcs_bank #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wrEn,
  input  logic                     othWr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [TAPS*DATA_W-1:0]   coefs
);
  localparam int PTR_W = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(TAPS - 1);

  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (!rst_n)                  ptr <= '0;
    else if (othWr)              ptr <= '0;
    else if (wrEn && ptr == LAST) ptr <= '0;
    else if (wrEn)               ptr <= ptr + 1'b1;
  end

  generate
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      always_ff @(posedge clk) begin
        if (!rst_n)
          coefs[t*DATA_W +: DATA_W] <= '0;
        else if (wrEn && ptr == PTR_W'(t))
          coefs[t*DATA_W +: DATA_W] <= wrData;
      end
    end
  endgenerate

  // R4: pointer never leaves the tap range
  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
  // R4: wrap after the last tap
  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !othWr && ptr == LAST) |=> ptr == '0);
  // R5: foreign write restarts the fill
  p_ptr_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    othWr |=> ptr == '0);
  // R3: taps only move on a write to this bank
  p_tap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> $stable(coefs));
endmodule

// File: rtl/kcs_datapath.sv
module kcs_datapath
  import kcs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TAPS   = 9,
  parameter int CFG_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  kcs_ctl_t               ctl,
  input  logic [DATA_W-1:0]      wrData,
  output logic [TAPS*DATA_W-1:0] coefOut,
  output logic [CFG_W-1:0]       cfgWord
);
  localparam int NBANK = 2;
  localparam int VEC_W = TAPS * DATA_W;

  logic [VEC_W-1:0] bankVec [NBANK];
  logic [NBANK-1:0] bankWr;
  logic             activeSel;

  assign bankWr = {ctl.wrB1, ctl.wrB0};

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      kcs_bank #(.DATA_W(DATA_W), .TAPS(TAPS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrEn   (bankWr[b]),
        .othWr  (ctl.anyWr & ~bankWr[b]),
        .wrData (wrData),
        .coefs  (bankVec[b])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)         activeSel <= 1'b0;
    else if (ctl.selB1) activeSel <= 1'b1;
    else if (ctl.selB0) activeSel <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         cfgWord <= '0;
    else if (ctl.wrCfg) cfgWord <= wrData[CFG_W-1:0];
  end

  assign coefOut = activeSel ? bankVec[1] : bankVec[0];

  // R6: writing the idle bank leaves the live kernel alone
  p_idle_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.wrB1 && !activeSel) |=> $stable(coefOut));
  // R6: select switches source on the next clock
  p_sel_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.selB1 |=> coefOut == bankVec[1]);
  // R8: configuration capture
  p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wrCfg |=> cfgWord == $past(wrData[CFG_W-1:0]));
  // R9: reserved codes change nothing visible
  p_quiet_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.anyWr && !(ctl.wrB0 | ctl.wrB1 | ctl.wrCfg | ctl.selB0 | ctl.selB1))
      |=> ($stable(coefOut) && $stable(cfgWord)));
endmodule

// File: rtl/kernel_coef_store.sv
module kernel_coef_store
  import kcs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TAPS        = 9,
  parameter int CFG_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frameClr,
  input  logic                   ldStb,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      dataIn,
  output logic [TAPS*DATA_W-1:0] coefOut,
  output logic [CFG_W-1:0]       cfgWord
);
  kcs_ctl_t ctl;

  kcs_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .frameClr (frameClr),
    .ldStb    (ldStb),
    .addr     (addr),
    .ctl      (ctl)
  );

  kcs_datapath #(.DATA_W(DATA_W), .TAPS(TAPS), .CFG_W(CFG_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .wrData  (dataIn),
    .coefOut (coefOut),
    .cfgWord (cfgWord)
  );

  // R10: frame clear never disturbs outputs
  p_frame_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frameClr |=> ($stable(coefOut) && $stable(cfgWord)));
endmodule

// File: tb/sim_kernel_coef_store.sv
module sim_kernel_coef_store;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 9;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frameClr = 1'b0;
  logic ldStb = 1'b0;
  logic [2:0] addr = 3'b111;
  logic [DW-1:0] dataIn = '0;
  logic [TAPS*DW-1:0] coefOut;
  logic [3:0] cfgWord;

  kernel_coef_store u0 (
    .clk(clk), .rst_n(rst_n), .frameClr(frameClr), .ldStb(ldStb),
    .addr(addr), .dataIn(dataIn), .coefOut(coefOut), .cfgWord(cfgWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [TAPS*DW-1:0] coef;
    logic [3:0]         cfg;
    string              tag;
  } exp_t;

  exp_t expQ[$];
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  // reference model state
  logic [TAPS*DW-1:0] mBank [2];
  int  mPtr [2];
  bit  mSel;
  logic [3:0] mCfg;

  function automatic logic [TAPS*DW-1:0] mOut();
    return mBank[mSel];
  endfunction

  task automatic push(string tag);
    exp_t e;
    e.coef = mOut();
    e.cfg  = mCfg;
    e.tag  = tag;
    expQ.push_back(e);
  endtask

  function automatic void modelWrite(logic [2:0] a, logic [DW-1:0] d);
    for (int b = 0; b < 2; b++) begin
      if (a == (b == 0 ? 3'b010 : 3'b011)) begin
        mBank[b][mPtr[b]*DW +: DW] = d;
        mPtr[b] = (mPtr[b] == TAPS - 1) ? 0 : mPtr[b] + 1;
      end else begin
        mPtr[b] = 0;
      end
    end
    case (a)
      3'b100: mCfg = d[3:0];
      3'b101: mSel = 1'b0;
      3'b110: mSel = 1'b1;
      default: ;
    endcase
  endfunction

  task automatic strobe(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk);
    addr = a; dataIn = d; ldStb = 1'b1;
    repeat (4) @(negedge clk);
    ldStb = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic doWrite(logic [2:0] a, logic [DW-1:0] d, string tag);
    strobe(a, d);
    modelWrite(a, d);
    push(tag);
  endtask

  task automatic cmp(logic [TAPS*DW-1:0] c, logic [3:0] f, string tag);
    nChecks++;
    if (coefOut !== c || cfgWord !== f) begin
      nFails++;
      $display("FAIL %s: coef=%h cfg=%h expected coef=%h cfg=%h",
               tag, coefOut, cfgWord, c, f);
    end
  endtask

  // monitor: pops expected items and compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        cmp(e.coef, e.cfg, e.tag);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    mBank[0] = '0; mBank[1] = '0; mPtr[0] = 0; mPtr[1] = 0;
    mSel = 1'b0; mCfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push("R7 reset state");

    doWrite(3'b100, 8'hA5, "R8 cfg low nibble");
    for (int i = 0; i < TAPS; i++)
      doWrite(3'b010, 8'(8'h11 * (i + 1)), "R3 bank0 fill A..I");
    doWrite(3'b010, 8'hE7, "R4 wrap to tap A");

    for (int i = 0; i < 5; i++)
      doWrite(3'b011, 8'(8'h80 + i), "R6 idle bank write hidden");
    doWrite(3'b010, 8'h3C, "R5 bank0 write clears bank1 pointer");
    doWrite(3'b110, 8'h00, "R6 select bank1");
    doWrite(3'b011, 8'h5A, "R5 bank1 restarts at A");
    doWrite(3'b011, 8'h6B, "R1 load code 011 fills bank1");

    doWrite(3'b000, 8'hFF, "R9 reserved 000");
    doWrite(3'b001, 8'hFF, "R9 reserved 001");
    doWrite(3'b111, 8'hFF, "R9 no-op 111");
    doWrite(3'b011, 8'h77, "R5 reserved write cleared pointer");

    // R10: frame clear between strobes
    @(negedge clk);
    frameClr = 1'b1;
    repeat (3) @(negedge clk);
    frameClr = 1'b0;
    @(negedge clk);
    push("R10 frame clear holds state");
    doWrite(3'b011, 8'h99, "R10 pointer kept across frame clear");

    doWrite(3'b101, 8'h00, "R6 select bank0");
    doWrite(3'b100, 8'h3E, "R8 cfg rewrite");

    // R2 latency: old after second sampling edge, new after third
    wait (expQ.size() == 0);
    @(negedge clk);
    addr = 3'b010; dataIn = 8'hC3; ldStb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cmp(mOut(), mCfg, "R2 no update after second edge");
    @(negedge clk);
    modelWrite(3'b010, 8'hC3);
    cmp(mOut(), mCfg, "R2 update after third edge");
    repeat (3) @(negedge clk);
    cmp(mOut(), mCfg, "R2 single write per strobe");
    ldStb = 1'b0;
    repeat (4) @(negedge clk);
    doWrite(3'b010, 8'h42, "R2 next strobe lands on next tap");

    wait (expQ.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule